// File: doc/BRIEF.md
# Hysteresis Bit Slicer with Edge-Locked Bit Timing

This block turns a stream of signed line-voltage samples, given in millivolts at a fixed sample rate, into a stream of data bits. A comparator with a programmable dead band around a fixed 5500 mV midpoint sets the line level. Samples that fall inside the dead band keep the previous level and raise a blank indication for that sample, so downstream drivers can stay quiet while the line is ambiguous.

Bit timing is recovered without a fixed-phase sampler. A run-length counter counts samples since the last level change. A second register, the committed length, is set to half the nominal bit length at each level change and is pushed forward by a full bit length each time a bit is emitted. A bit is emitted whenever the run reaches the committed length. Every level change therefore re-centres the sampling point, so the first bit after an edge falls half a period later and the following bits one period apart.

The block sits between a sampling front end and a symbol decoder. Software-free operation: the hysteresis width and the nominal bit length are plain inputs, usually tied to 6000 mV and 40 samples.

Top module: `hyst_bit_recovery`

## Requirements
- R1: A synchronous active-high reset clears the stored level to 0, both counters to 0 and all three outputs to 0.
- R2: For each valid sample, with `d = sample - 5500` (sample in two's complement mV), the level becomes 1 when `d > floor(hys/2)` and 0 when `d < -floor(hys/2)`.
- R3: When `-floor(hys/2) <= d <= floor(hys/2)` (bounds inclusive) the stored level is kept and `blank_o` is 1 for that sample.
- R4: All outputs are registered: `bit_vld_o` and `blank_o` reflect the sample presented in the previous clock cycle and are 0 in any cycle after a cycle with `smp_vld_i` low.
- R5: A sample that changes the level never emits a bit; it counts as index 0 of the new run, and the first bit of the run is emitted on the sample with index `floor(len/2)`.
- R6: While the level is unchanged, further bits are emitted every `len` samples after the first, with `bit_o` equal to the stored level.
- R7: The run counter and the committed length are `CNT_W` bits wide and saturate at `2**CNT_W-1`; once the run counter is saturated no bit is emitted until the next level change.
- R8: A dead-band sample that lands on a bit instant emits that bit (the stored level) and asserts `blank_o` in the same cycle.
- R9: An ideal two-level waveform whose edges are each displaced by up to one tenth of the bit length from the nominal grid is recovered bit for bit.
- R10: Cycles with `smp_vld_i` low leave the level and both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | Sample strobe |
| smp_mv_i | input | SMP_W | Signed line voltage in mV |
| hys_mv_i | input | HYS_W | Full width of the dead band in mV |
| bit_len_i | input | CNT_W | Nominal bit length in samples |
| bit_vld_o | output | 1 | A recovered bit is present |
| bit_o | output | 1 | Recovered bit value, valid with `bit_vld_o` |
| blank_o | output | 1 | Previous sample lay inside the dead band |

## Verification
A bit emission and a blank indication can fall in the same cycle when a dead-band sample arrives exactly on a bit instant, since such a sample keeps the level and advances the run. The bench provokes this right after reset, where the committed length is zero and the very first sample is placed at the midpoint, and again in a random phase that mixes in-band and out-of-band samples. Both outputs are judged in that cycle against a bench model built from the requirements, which expects `bit_vld_o`, `blank_o` and the held level together.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   // Fixed decision midpoint of the line, in mV
   localparam int MIDPOINT_MV     = 5500;
   localparam int DEF_HYS_MV      = 6000;
   localparam int DEF_BIT_LEN     = 40;
   localparam int DEF_SMP_W       = 16;
   localparam int DEF_HYS_W       = 16;
   localparam int DEF_CNT_W       = 16;

   typedef struct packed {
      logic above;
      logic below;
      logic in_band;
   } cmp_res_t;
endpackage

// File: rtl/hbr_level_slicer.sv
module hbr_level_slicer
   import hbr_pkg::*;
#(
   parameter int SMP_W = DEF_SMP_W,
   parameter int HYS_W = DEF_HYS_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_vld_i,
   input  logic signed [SMP_W-1:0] smp_i,
   input  logic [HYS_W-1:0]        hys_i,
   output logic                    level_q_o,
   output logic                    level_n_o,
   output logic                    edge_o,
   output logic                    blank_q_o
);
   localparam int DW = ((SMP_W > HYS_W) ? SMP_W : HYS_W) + 2;

   generate
      if (SMP_W < 15 || SMP_W > 30) begin : g_bad_smp_w
         $error("SMP_W must hold the midpoint and stay below 31 bits");
      end
      if (HYS_W < 2 || HYS_W > 30) begin : g_bad_hys_w
         $error("HYS_W out of range");
      end
   endgenerate

   logic signed [DW-1:0] diff;
   logic signed [DW-1:0] half;
   cmp_res_t             cmp;
   logic                 level_q;
   logic                 blank_q;

   always_comb begin
      diff        = DW'(smp_i) - DW'(MIDPOINT_MV);
      half        = DW'({1'b0, hys_i[HYS_W-1:1]});
      cmp.above   = diff > half;
      cmp.below   = diff < -half;
      cmp.in_band = !(cmp.above || cmp.below);
   end

   always_comb begin
      level_n_o = level_q;
      if (cmp.above)      level_n_o = 1'b1;
      else if (cmp.below) level_n_o = 1'b0;
   end

   assign edge_o    = smp_vld_i && (level_n_o != level_q);
   assign level_q_o = level_q;
   assign blank_q_o = blank_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= 1'b0;
         blank_q <= 1'b0;
      end else begin
         blank_q <= smp_vld_i && cmp.in_band;
         if (smp_vld_i) level_q <= level_n_o;
      end
   end

   // R3: an in-band sample never moves the stored level
   assert_band_keeps_level_R3: assert property (@(posedge clk) disable iff (rst)
      (smp_vld_i && cmp.in_band) |=> $stable(level_q));
   // R2: a sample above the band forces level 1, below forces 0
   assert_above_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (smp_vld_i && cmp.above) |=> level_q);
   assert_below_clears_R2: assert property (@(posedge clk) disable iff (rst)
      (smp_vld_i && cmp.below) |=> !level_q);
   // R10: idle cycles keep the level
   assert_idle_level_R10: assert property (@(posedge clk) disable iff (rst)
      !smp_vld_i |=> $stable(level_q) && !blank_q);
endmodule

// File: rtl/hbr_bit_timer.sv
module hbr_bit_timer
   import hbr_pkg::*;
#(
   parameter int CNT_W = DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_vld_i,
   input  logic             edge_i,
   input  logic             level_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             bit_vld_o,
   output logic             bit_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 4 || CNT_W > 31) begin : g_bad_cnt_w
         $error("CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] run_q, commit_q;
   logic [CNT_W:0]   run_inc, commit_sum;
   logic             run_sat, due;
   logic             bit_vld_q, bit_q;

   always_comb begin
      run_inc    = {1'b0, run_q} + 1'b1;
      commit_sum = {1'b0, commit_q} + {1'b0, len_i};
      run_sat    = (run_q == CNT_MAX);
      due        = !run_sat && (run_inc >= {1'b0, commit_q});
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q     <= '0;
         commit_q  <= '0;
         bit_vld_q <= 1'b0;
         bit_q     <= 1'b0;
      end else begin
         bit_vld_q <= 1'b0;
         if (smp_vld_i) begin
            if (edge_i) begin
               run_q    <= '0;
               commit_q <= len_i >> 1;
            end else begin
               if (!run_sat) run_q <= run_inc[CNT_W-1:0];
               if (due) begin
                  commit_q  <= commit_sum[CNT_W] ? CNT_MAX : commit_sum[CNT_W-1:0];
                  bit_vld_q <= 1'b1;
                  bit_q     <= level_i;
               end
            end
         end
      end
   end

   assign bit_vld_o = bit_vld_q;
   assign bit_o     = bit_q;

   // R5: an edge sample emits nothing and restarts the run
   assert_edge_no_bit_R5: assert property (@(posedge clk) disable iff (rst)
      (smp_vld_i && edge_i) |=> !bit_vld_q && (run_q == '0));
   // R7: a saturated run stays saturated and silent until an edge
   assert_run_saturates_R7: assert property (@(posedge clk) disable iff (rst)
      (smp_vld_i && !edge_i && run_sat) |=> (run_q == CNT_MAX) && !bit_vld_q);
   // R10: idle cycles leave both counters alone
   assert_idle_counters_R10: assert property (@(posedge clk) disable iff (rst)
      !smp_vld_i |=> $stable(run_q) && $stable(commit_q) && !bit_vld_q);
   // R6: an emitted bit moves the committed length forward
   assert_commit_grows_R6: assert property (@(posedge clk) disable iff (rst)
      (smp_vld_i && !edge_i && due && len_i != '0 && commit_q != CNT_MAX)
         |=> commit_q > $past(commit_q));
endmodule

// File: rtl/hyst_bit_recovery.sv
module hyst_bit_recovery
   import hbr_pkg::*;
#(
   parameter int SMP_W = DEF_SMP_W,
   parameter int HYS_W = DEF_HYS_W,
   parameter int CNT_W = DEF_CNT_W
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_vld_i,
   input  logic signed [SMP_W-1:0] smp_mv_i,
   input  logic [HYS_W-1:0]        hys_mv_i,
   input  logic [CNT_W-1:0]        bit_len_i,
   output logic                    bit_vld_o,
   output logic                    bit_o,
   output logic                    blank_o
);
   logic level_q, level_n, edge_s;

   hbr_level_slicer #(.SMP_W(SMP_W), .HYS_W(HYS_W)) slicer_i (
      .clk       (clk),
      .rst       (rst),
      .smp_vld_i (smp_vld_i),
      .smp_i     (smp_mv_i),
      .hys_i     (hys_mv_i),
      .level_q_o (level_q),
      .level_n_o (level_n),
      .edge_o    (edge_s),
      .blank_q_o (blank_o)
   );

   hbr_bit_timer #(.CNT_W(CNT_W)) timer_i (
      .clk       (clk),
      .rst       (rst),
      .smp_vld_i (smp_vld_i),
      .edge_i    (edge_s),
      .level_i   (level_n),
      .len_i     (bit_len_i),
      .bit_vld_o (bit_vld_o),
      .bit_o     (bit_o)
   );

   // R4: no output activity follows an idle cycle
   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      !smp_vld_i |=> !bit_vld_o && !blank_o);
   // R6: an emitted bit carries the level that was stored
   assert_bit_is_level_R6: assert property (@(posedge clk) disable iff (rst)
      bit_vld_o |-> (bit_o == level_q));
endmodule

// File: tb/hyst_bit_recovery_tb_top.sv
`timescale 1ns/1ps
module hyst_bit_recovery_tb_top;
   localparam int CNT_W = 10;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_vld = 1'b0;
   logic signed [15:0] smp_mv = '0;
   logic [15:0] hys_mv = 16'd6000;
   logic [CNT_W-1:0] bit_len = CNT_W'(40);
   logic bit_vld, bit_val, blank;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   int m_lvl, m_run, m_com;
   logic rx_bits [0:255];
   int rx_n;
   logic tx_bits [0:255];

   always #2.5 clk = ~clk;

   hyst_bit_recovery #(.SMP_W(16), .HYS_W(16), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst(rst), .smp_vld_i(smp_vld), .smp_mv_i(smp_mv),
      .hys_mv_i(hys_mv), .bit_len_i(bit_len),
      .bit_vld_o(bit_vld), .bit_o(bit_val), .blank_o(blank));

   task automatic check(input string tag, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void model(input int s, output bit e_bv, output bit e_bit, output bit e_bl);
      int diff, half, nl, old;
      diff = s - 5500; half = int'(hys_mv) / 2;
      nl = m_lvl; e_bl = 0; e_bv = 0;
      if (diff < -half) nl = 0;
      else if (diff > half) nl = 1;
      else e_bl = 1;
      if (nl != m_lvl) begin
         m_lvl = nl; m_run = 0; m_com = int'(bit_len) / 2;
      end else begin
         old = m_run;
         if (m_run < CMAX) m_run++;
         if (old < CMAX && old + 1 >= m_com) begin
            m_com = (m_com + int'(bit_len) > CMAX) ? CMAX : m_com + int'(bit_len);
            e_bv = 1;
         end
      end
      e_bit = m_lvl[0];
   endfunction

   // called at a negedge; returns at the negedge after the sample is registered
   task automatic put(input int s, input string tag);
      bit e_bv, e_bit, e_bl;
      smp_vld = 1'b1; smp_mv = 16'(s);
      model(s, e_bv, e_bit, e_bl);
      @(negedge clk);
      check(tag, bit_vld == e_bv, int'(bit_vld), int'(e_bv));
      check(tag, blank == e_bl, int'(blank), int'(e_bl));
      if (e_bv) check(tag, bit_val == e_bit, int'(bit_val), int'(e_bit));
      if (bit_vld && rx_n < 256) begin rx_bits[rx_n] = bit_val; rx_n++; end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         smp_vld = 1'b0; smp_mv = 16'(5500);
         @(negedge clk);
         check("R4", !bit_vld && !blank, int'(bit_vld) + 2 * int'(blank), 0);
      end
   endtask

   task automatic do_reset();
      smp_vld = 1'b0; rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_lvl = 0; m_run = 0; m_com = 0; rx_n = 0;
   endtask

   initial begin
      int first, cnt, last, jp, jn, len, ok;
      void'($urandom(32'd4711));
      @(negedge clk);
      do_reset();
      // R1: outputs clear after reset
      check("R1", !bit_vld && !bit_val && !blank, int'(bit_vld) + int'(bit_val) + int'(blank), 0);
      // R8: midpoint sample right after reset: emits stored level 0 and blanks
      put(5500, "R8");
      check("R8", bit_vld && blank && !bit_val, int'(bit_vld) + int'(blank), 2);
      check("R1", !bit_val, int'(bit_val), 0);

      // R2/R3 boundaries: 8500 inside, 8501 above, 2500 inside, 2499 below
      put(8500, "R3"); check("R3", blank, int'(blank), 1);
      put(8501, "R2"); check("R2", !blank && !bit_vld, int'(blank), 0);
      put(8500, "R3"); check("R3", blank == 1'b1, int'(blank), 1);
      put(2500, "R3"); check("R3", blank == 1'b1, int'(blank), 1);
      put(2499, "R2"); check("R2", !blank, int'(blank), 0);

      // R5/R6: bit instants at run indices 20, 60, 100
      do_reset();
      first = -1; cnt = 0; ok = 1;
      for (int i = 0; i <= 120; i++) begin
         put(9500, "R5");
         if (bit_vld) begin
            if (first < 0) first = i;
            cnt++;
            if (i != 20 && i != 60 && i != 100) ok = 0;
            check("R6", bit_val == 1'b1, int'(bit_val), 1);
         end
      end
      check("R5", first == 20, first, 20);
      check("R6", cnt == 3 && ok == 1, cnt, 3);

      // R10: idle gaps do not disturb timing
      for (int i = 0; i < 30; i++) begin
         put(1000, "R10");
         if (i % 7 == 3) idle(2);
      end

      // R9: jittered two-level stream, leading 1 then 60 random bits
      do_reset();
      tx_bits[0] = 1'b1;
      for (int k = 1; k <= 60; k++) tx_bits[k] = 1'($urandom_range(0, 1));
      jp = 0;
      for (int k = 0; k <= 60; k++) begin
         jn = int'($urandom_range(0, 8)) - 4;
         len = 40 + jn - jp;
         jp = jn;
         for (int i = 0; i < len; i++)
            put(tx_bits[k] ? 9000 + int'($urandom_range(0, 3000))
                           : 2000 - int'($urandom_range(0, 3000)), "R9");
      end
      check("R9", rx_n == 61, rx_n, 61);
      for (int k = 0; k <= 60 && k < rx_n; k++)
         check("R9", rx_bits[k] == tx_bits[k], int'(rx_bits[k]), int'(tx_bits[k]));

      // R2/R3/R8 random mix with other settings, including idle cycles
      do_reset();
      hys_mv = 16'd1000; bit_len = CNT_W'(16);
      for (int i = 0; i < 600; i++) begin
         put(int'($urandom_range(3500, 7500)), "R2");
         if ($urandom_range(0, 20) == 0) idle(1);
      end
      hys_mv = 16'd6000; bit_len = CNT_W'(40);

      // R7: constant line from reset, 1500 samples -> 27 bits, last at sample 1023
      do_reset();
      cnt = 0; last = 0;
      for (int i = 1; i <= 1500; i++) begin
         put(0, "R7");
         if (bit_vld) begin cnt++; last = i; end
      end
      check("R7", cnt == 27, cnt, 27);
      check("R7", last == 1023, last, 1023);
      // an edge ends saturation: first bit again at index 20
      first = -1;
      for (int i = 0; i <= 30; i++) begin
         put(9500, "R7");
         if (bit_vld && first < 0) first = i;
      end
      check("R7", first == 20, first, 20);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule